// File: doc/BRIEF.md
# Condition Flag Register for an Instruction Sequencer

This block keeps the sixteen condition flags that a message-sequencing instruction processor tests before it runs a conditional instruction. The upper eight flags (indices 8 to 15) report the outcome of the message that finished most recently. They are loaded together whenever the message engine pulses its result strobe. The lower eight flags (indices 0 to 7) are general-purpose flags. Two masters can set, clear or toggle each of them on its own: the host, through a register write, and the sequencer, through its flag instruction. A timer-compare instruction can also overwrite the two lowest flags with its compare results.

The sequencer chooses one flag with a 4-bit select and gives a polarity bit. The block returns whether the chosen flag matches that polarity. The host sees all sixteen flags on a read-only port. The message engine and the timers sit outside the block. Their results come in as plain inputs.

Top module: `cc_flag_reg`

## Requirements
- R1: While rst_ni is low, all sixteen flags read as 0 on cc_rd_o.
- R2: A host write (host_we_i high) changes each general-purpose flag k by its mask bits host_set_i[k] and host_clr_i[k]. Set only gives 1. Clear only gives 0. Both give the inverted flag. Neither leaves the flag unchanged. The new value appears on cc_rd_o[7:0] after the next clock edge.
- R3: A sequencer flag instruction (seq_flg_i high) changes the general-purpose flags with the same set/clear/toggle encoding, using seq_set_i and seq_clr_i. It can change any or all of the eight flags in one cycle.
- R4: A timer compare (tmr_cmp_i high) writes flag 0 with tmr_lt_i and flag 1 with tmr_eq_i. It leaves flags 2 to 7 and flags 8 to 15 unchanged.
- R5: A result strobe (res_vld_i high) loads res_bits_i[j] into flag 8+j for every j. Flags 8 to 15 keep their values in every cycle without a strobe, and no general-purpose write source changes them.
- R6: When several sources write in the same cycle, the order is fixed. The host update comes first. The timer compare is applied next, and the sequencer flag instruction last, each working on the result of the one before it.
- R7: cc_true_o is high exactly when flag cc_sel_i of the current register value equals cc_pol_i. It follows cc_sel_i and cc_pol_i with no clock delay.
- R8: cc_rd_o presents the register directly: bits 15:8 are the result flags and bits 7:0 are the general-purpose flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write to the general-purpose flags |
| host_set_i | input | 8 | Host set mask |
| host_clr_i | input | 8 | Host clear mask |
| seq_flg_i | input | 1 | Sequencer flag instruction valid |
| seq_set_i | input | 8 | Sequencer set mask |
| seq_clr_i | input | 8 | Sequencer clear mask |
| tmr_cmp_i | input | 1 | Timer compare instruction valid |
| tmr_lt_i | input | 1 | Compare less-than result, written to flag 0 |
| tmr_eq_i | input | 1 | Compare equal result, written to flag 1 |
| res_vld_i | input | 1 | Message result strobe |
| res_bits_i | input | 8 | Message result bits for flags 8 to 15 |
| cc_sel_i | input | 4 | Index of the flag under test |
| cc_pol_i | input | 1 | Polarity the tested flag must match |
| cc_true_o | output | 1 | Condition test result |
| cc_rd_o | output | 16 | All flags, read-only host view |

## Verification
Every write source (host mask, timer compare, sequencer mask, result strobe) sets up a next-state value that is registered once. Its effect is therefore due on cc_rd_o one clock edge after the cycle in which it is driven. cc_true_o is combinational from that register and the select and polarity inputs, so it is due in the same cycle as the register value it reads. The driver applies each stimulus at a falling edge and queues the expected register value and test result. The monitor checks them shortly after the following rising edge, while the select and polarity are still held steady.

// File: rtl/cc_flag_pkg.sv
package cc_flag_pkg;
  localparam int unsigned CC_GP_W  = 8;
  localparam int unsigned CC_RES_W = 8;
  localparam int unsigned CC_NUM   = CC_GP_W + CC_RES_W;
  localparam int unsigned CC_SEL_W = $clog2(CC_NUM);

  typedef enum logic [1:0] {
    MASK_KEEP = 2'b00,
    MASK_SET  = 2'b01,
    MASK_CLR  = 2'b10,
    MASK_TOG  = 2'b11
  } mask_act_e;
endpackage

// File: rtl/cc_mask_stage.sv
module cc_mask_stage #(
  parameter int unsigned W = 8
) (
  input  logic         en_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  import cc_flag_pkg::*;

  for (genvar k = 0; k < W; k++) begin : g_bit
    mask_act_e act;
    assign act = en_i ? mask_act_e'({clr_i[k], set_i[k]}) : MASK_KEEP;
    always_comb begin
      unique case (act)
        MASK_SET: q_o[k] = 1'b1;
        MASK_CLR: q_o[k] = 1'b0;
        MASK_TOG: q_o[k] = ~d_i[k];
        default:  q_o[k] = d_i[k];
      endcase
    end
  end
endmodule

// File: rtl/cc_gp_bank.sv
module cc_gp_bank #(
  parameter int unsigned NUM_GP = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [NUM_GP-1:0] host_set_i,
  input  logic [NUM_GP-1:0] host_clr_i,
  input  logic              tmr_cmp_i,
  input  logic              tmr_lt_i,
  input  logic              tmr_eq_i,
  input  logic              seq_flg_i,
  input  logic [NUM_GP-1:0] seq_set_i,
  input  logic [NUM_GP-1:0] seq_clr_i,
  output logic [NUM_GP-1:0] gp_o
);
  localparam int unsigned NUM_TMR = 2;

  logic [NUM_GP-1:0] gp_q, after_host, after_tmr, gp_d;

  // host first, then timer compare, then sequencer flag instruction
  cc_mask_stage #(.W(NUM_GP)) i_host_stage (
    .en_i (host_we_i), .set_i(host_set_i), .clr_i(host_clr_i),
    .d_i  (gp_q),      .q_o  (after_host)
  );

  for (genvar k = 0; k < NUM_GP; k++) begin : g_tmr
    if (k == 0) begin : g_lt
      assign after_tmr[k] = tmr_cmp_i ? tmr_lt_i : after_host[k];
    end else if (k < NUM_TMR) begin : g_eq
      assign after_tmr[k] = tmr_cmp_i ? tmr_eq_i : after_host[k];
    end else begin : g_pass
      assign after_tmr[k] = after_host[k];
    end
  end

  cc_mask_stage #(.W(NUM_GP)) i_seq_stage (
    .en_i (seq_flg_i), .set_i(seq_set_i), .clr_i(seq_clr_i),
    .d_i  (after_tmr), .q_o  (gp_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gp_q <= '0;
    else         gp_q <= gp_d;
  end

  assign gp_o = gp_q;
endmodule

// File: rtl/cc_res_bank.sv
module cc_res_bank #(
  parameter int unsigned NUM_RES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               res_vld_i,
  input  logic [NUM_RES-1:0] res_bits_i,
  output logic [NUM_RES-1:0] res_o
);
  logic [NUM_RES-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        res_q <= '0;
    else if (res_vld_i) res_q <= res_bits_i;
  end

  assign res_o = res_q;
endmodule

// File: rtl/cc_test_sel.sv
module cc_test_sel #(
  parameter int unsigned NUM_CC = 16,
  parameter int unsigned SEL_W  = $clog2(NUM_CC)
) (
  input  logic [NUM_CC-1:0] cc_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              pol_i,
  output logic              hit_o
);
  logic picked;
  assign picked = cc_i[sel_i];
  assign hit_o  = ~(picked ^ pol_i);
endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import cc_flag_pkg::*;
#(
  parameter int unsigned NUM_GP  = CC_GP_W,
  parameter int unsigned NUM_RES = CC_RES_W,
  localparam int unsigned NUM_CC = NUM_GP + NUM_RES,
  localparam int unsigned SEL_W  = $clog2(NUM_CC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_we_i,
  input  logic [NUM_GP-1:0]  host_set_i,
  input  logic [NUM_GP-1:0]  host_clr_i,
  input  logic               seq_flg_i,
  input  logic [NUM_GP-1:0]  seq_set_i,
  input  logic [NUM_GP-1:0]  seq_clr_i,
  input  logic               tmr_cmp_i,
  input  logic               tmr_lt_i,
  input  logic               tmr_eq_i,
  input  logic               res_vld_i,
  input  logic [NUM_RES-1:0] res_bits_i,
  input  logic [SEL_W-1:0]   cc_sel_i,
  input  logic               cc_pol_i,
  output logic               cc_true_o,
  output logic [NUM_CC-1:0]  cc_rd_o
);
  logic [NUM_GP-1:0]  gp_flags;
  logic [NUM_RES-1:0] res_flags;

  cc_gp_bank #(.NUM_GP(NUM_GP)) i_gp_bank (
    .clk_i, .rst_ni,
    .host_we_i, .host_set_i, .host_clr_i,
    .tmr_cmp_i, .tmr_lt_i, .tmr_eq_i,
    .seq_flg_i, .seq_set_i, .seq_clr_i,
    .gp_o (gp_flags)
  );

  cc_res_bank #(.NUM_RES(NUM_RES)) i_res_bank (
    .clk_i, .rst_ni,
    .res_vld_i, .res_bits_i,
    .res_o (res_flags)
  );

  assign cc_rd_o = {res_flags, gp_flags};

  cc_test_sel #(.NUM_CC(NUM_CC), .SEL_W(SEL_W)) i_test_sel (
    .cc_i  (cc_rd_o),
    .sel_i (cc_sel_i),
    .pol_i (cc_pol_i),
    .hit_o (cc_true_o)
  );
endmodule

// File: rtl/cc_flag_reg_chk.sv
module cc_flag_reg_chk
  import cc_flag_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                host_we_i,
  input logic [CC_GP_W-1:0]  host_set_i,
  input logic [CC_GP_W-1:0]  host_clr_i,
  input logic                seq_flg_i,
  input logic [CC_GP_W-1:0]  seq_set_i,
  input logic [CC_GP_W-1:0]  seq_clr_i,
  input logic                tmr_cmp_i,
  input logic                tmr_lt_i,
  input logic                tmr_eq_i,
  input logic                res_vld_i,
  input logic [CC_RES_W-1:0] res_bits_i,
  input logic [CC_SEL_W-1:0] cc_sel_i,
  input logic                cc_pol_i,
  input logic                cc_true_o,
  input logic [CC_NUM-1:0]   cc_rd_o
);
  assert_res_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_i |=> cc_rd_o[CC_NUM-1:CC_GP_W] == $past(res_bits_i));

  assert_res_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_i |=> $stable(cc_rd_o[CC_NUM-1:CC_GP_W]));

  assert_gp_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_we_i && !seq_flg_i && !tmr_cmp_i) |=> $stable(cc_rd_o[CC_GP_W-1:0]));

  assert_tmr_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_cmp_i && !seq_flg_i) |=> cc_rd_o[1:0] == {$past(tmr_eq_i), $past(tmr_lt_i)});

  assert_tmr_upper_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_cmp_i && !seq_flg_i && !host_we_i) |=> $stable(cc_rd_o[CC_GP_W-1:2]));

  assert_seq_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_flg_i && host_we_i && ((seq_set_i ^ seq_clr_i) == '1))
      |=> cc_rd_o[CC_GP_W-1:0] == $past(seq_set_i));

  assert_test_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_true_o == (cc_rd_o[cc_sel_i] == cc_pol_i));
endmodule

bind cc_flag_reg cc_flag_reg_chk i_cc_flag_reg_chk (.*);

// File: tb/test_cc_flag_reg.sv
`timescale 1ns/1ps
module test_cc_flag_reg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_we_i = 1'b0, seq_flg_i = 1'b0, tmr_cmp_i = 1'b0, res_vld_i = 1'b0;
  logic [7:0]  host_set_i = '0, host_clr_i = '0, seq_set_i = '0, seq_clr_i = '0;
  logic        tmr_lt_i = 1'b0, tmr_eq_i = 1'b0, cc_pol_i = 1'b0;
  logic [7:0]  res_bits_i = '0;
  logic [3:0]  cc_sel_i = '0;
  logic        cc_true_o;
  logic [15:0] cc_rd_o;

  always #2.5 clk_i = ~clk_i;

  cc_flag_reg i_cc_flag_reg (.*);

  typedef struct {
    logic [15:0] rd;
    logic        tr;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] model = '0;

  // stimulus staged by the test sequence
  logic s_hw, s_sf, s_tc, s_rv, s_lt, s_eq, s_pol;
  logic [7:0] s_hs, s_hc, s_ss, s_sc, s_rb;
  logic [3:0] s_sel;

  function automatic logic [7:0] upd(input logic [7:0] v, s, c);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) begin
      if (s[k] && c[k]) r[k] = !v[k];
      else if (s[k])    r[k] = 1'b1;
      else if (c[k])    r[k] = 1'b0;
      else              r[k] = v[k];
    end
    return r;
  endfunction

  task automatic clr_stim();
    {s_hw, s_sf, s_tc, s_rv, s_lt, s_eq, s_pol} = '0;
    {s_hs, s_hc, s_ss, s_sc, s_rb} = '0;
    s_sel = '0;
  endtask

  task automatic push(input string tag);
    item_t it;
    logic [7:0] gp;
    @(negedge clk_i);
    host_we_i = s_hw; host_set_i = s_hs; host_clr_i = s_hc;
    seq_flg_i = s_sf; seq_set_i = s_ss; seq_clr_i = s_sc;
    tmr_cmp_i = s_tc; tmr_lt_i = s_lt; tmr_eq_i = s_eq;
    res_vld_i = s_rv; res_bits_i = s_rb;
    cc_sel_i = s_sel; cc_pol_i = s_pol;
    gp = model[7:0];
    if (s_hw) gp = upd(gp, s_hs, s_hc);
    if (s_tc) begin gp[0] = s_lt; gp[1] = s_eq; end
    if (s_sf) gp = upd(gp, s_ss, s_sc);
    model[7:0] = gp;
    if (s_rv) model[15:8] = s_rb;
    it.rd = model;
    it.tr = (model[s_sel] == s_pol);
    it.tag = tag;
    sb_q.push_back(it);
    clr_stim();
  endtask

  // monitor: checks the value registered at the edge after each drive
  always begin
    item_t it;
    @(posedge clk_i);
    #1;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      tests++;
      if (cc_rd_o !== it.rd) begin
        fails++;
        $display("FAIL %s cc_rd_o actual=%h expected=%h", it.tag, cc_rd_o, it.rd);
      end
      tests++;
      if (cc_true_o !== it.tr) begin
        fails++;
        $display("FAIL %s/R7 cc_true_o actual=%b expected=%b", it.tag, cc_true_o, it.tr);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clr_stim();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    tests++;
    if (cc_rd_o !== 16'h0000) begin
      fails++;
      $display("FAIL R1 reset flags actual=%h expected=%h", cc_rd_o, 16'h0000);
    end
    tests++;
    if (cc_true_o !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset test output actual=%b expected=%b", cc_true_o, 1'b1);
    end
    rst_ni = 1'b1;

    // R2 host masks
    s_hw = 1; s_hs = 8'hA5;                push("R2 set");
    s_hw = 1; s_hc = 8'h05; s_sel = 4'd7; s_pol = 1; push("R2 clear");
    s_hw = 1; s_hs = 8'hFF; s_hc = 8'hFF;  push("R2 toggle");
    s_hw = 1; s_hs = 8'h01; s_hc = 8'h02;  push("R2 mixed");
    // R3 sequencer masks
    s_sf = 1; s_ss = 8'h30; s_sc = 8'h18; s_sel = 4'd4; push("R3 mixed");
    s_sf = 1; s_ss = 8'hFF;                push("R3 set all");
    s_sf = 1; s_sc = 8'hFF;                push("R3 clear all");
    s_sf = 1; s_ss = 8'h3C; s_sc = 8'h3C;  push("R3 toggle");
    // R5 result flags, R8 bit placement
    s_rv = 1; s_rb = 8'h3C; s_sel = 4'd10; s_pol = 1; push("R5 load");
    s_sel = 4'd8;                          push("R5 hold");
    s_hw = 1; s_hs = 8'hFF; s_hc = 8'hFF; s_sel = 4'd13; s_pol = 1; push("R5 host no effect");
    s_rv = 1; s_rb = 8'hC1; s_sf = 1; s_ss = 8'h81; s_sel = 4'd15; s_pol = 1; push("R8 result and gp together");
    // R4 timer compare
    s_tc = 1; s_lt = 1; s_eq = 0;          push("R4 lt");
    s_tc = 1; s_lt = 0; s_eq = 1; s_sel = 4'd1; s_pol = 1; push("R4 eq");
    s_tc = 1; s_lt = 1; s_eq = 1;          push("R4 both");
    s_tc = 1; s_lt = 0; s_eq = 0;          push("R4 none");
    // R6 ordering
    s_hw = 1; s_hs = 8'h80; s_sf = 1; s_sc = 8'h80; s_sel = 4'd7; push("R6 seq clear wins");
    s_hw = 1; s_hc = 8'h40; s_sf = 1; s_ss = 8'h40; s_sel = 4'd6; s_pol = 1; push("R6 seq set wins");
    s_hw = 1; s_hs = 8'h04; s_hc = 8'h04; s_sf = 1; s_ss = 8'h04; s_sc = 8'h04; push("R6 double toggle");
    s_tc = 1; s_lt = 0; s_eq = 0; s_sf = 1; s_ss = 8'h03; push("R6 seq after timer");
    s_hw = 1; s_hs = 8'h03; s_tc = 1; s_lt = 0; s_eq = 1; push("R6 timer after host");
    // R7 sweep of select and polarity
    for (int i = 0; i < 32; i++) begin
      s_sel = i[3:0]; s_pol = i[4];
      push("R7 sweep");
    end
    push("idle");
    wait (sb_q.size() == 0);
    repeat (2) @(posedge clk_i);
    finish_run();
  end
endmodule